// File: doc/BRIEF.md
# Digit-serial decimal logarithm engine

This block produces the base-10 logarithm of a positive sixteen-digit BCD number, one result digit per step. The operand arrives as sixteen nibble positions. At most one position may carry the point code 4'hA, which marks the decimal point. With no point code present, the point sits just below the least significant position. After `start`, the engine first derives the characteristic. It then derives the requested number of fraction digits. It uses no tables, no division and no conversion to binary.

Each step works in three stages. The engine counts the integer digits of the current value, counting from the first nonzero digit. That count minus one is the result digit. The engine then left-aligns the value's digits so that the implied point sits right after the leading digit, which divides the value by the matching power of ten. It hands that normalised value to an external power unit that returns the tenth power. A single scanner, fed through a 2:1 selector, serves both the start operand and every power-unit reply.

The result is signed. It consists of a sign flag, a two-digit BCD integer part, the fraction digits (first digit in the top nibble) and the fraction length, which gives the position of the result's decimal point. An all-zero operand yields an error instead of a result.

Top module: `declog_engine`

## Requirements
- R1: After reset, `done`, `busy`, `pw_req`, `res_err`, `res_neg`, `res_int`, `res_frac` and `res_len` are all zero.
- R2: For an operand of at least 1, `res_int` holds, as two BCD digits (tens in [7:4]), the number of digits above the point (the point code 4'hA, or below position 0 if no such code is present) counted from the first nonzero digit, minus one.
- R3: Each power request is a one-cycle `pw_req` pulse. During that pulse, `pw_operand` holds the current value's digits with the point code and leading zeros removed, left-aligned to the top nibble and zero-filled at the bottom. The implied point lies below the top digit.
- R4: Each fraction digit equals the integer-digit count of the accepted `pw_result` minus one. The digits fill `res_frac` from the top nibble downward in the order they are produced, and unused nibbles are zero.
- R5: Exactly `frac_cnt` power requests are issued per accepted start, and none when `frac_cnt` is 0. `done` follows the last accepted reply.
- R6: An operand below 1 gives a negative characteristic n, equal to minus one more than the count of zeros between the point and the first nonzero digit. The fraction steps then run on the normalised mantissa m, so that the log equals n + log10(m).
- R7: When the characteristic n is negative, `res_neg` is 1. If the fraction f is nonzero, `res_frac` holds the ten's complement of f over its length and `res_int` holds |n|-1. If f is zero, `res_frac` is zero and `res_int` holds |n|.
- R8: An operand with no nonzero digit sets `res_err` with `done`, issues no power request, and leaves `res_neg`, `res_int`, `res_frac` and `res_len` zero.
- R9: A `start` asserted while `busy` is 1 is ignored. The running computation and its result are unaffected.
- R10: `done` is high for exactly one cycle per accepted start. The result outputs change only in that cycle and hold until the next result.
- R11: A `frac_cnt` above FRAC_MAX (default 8) is treated as FRAC_MAX.
- R12: `res_len` reports the number of fraction digits produced, which is the position of the result's decimal point counted from the top of `res_frac`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation; sampled only while idle |
| in_digits | input | 4*NDIG | Operand digits, top nibble most significant, 4'hA marks the point |
| frac_cnt | input | CW | Requested fraction digits (clamped to FRAC_MAX) |
| pw_ack | input | 1 | Power unit reply strobe |
| pw_result | input | 4*NDIG | Tenth power of the last operand, same format as `in_digits` |
| pw_req | output | 1 | One-cycle request to the power unit |
| pw_operand | output | 4*NDIG | Normalised value to raise, point below the top digit |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_err | output | 1 | Operand had no nonzero digit |
| res_neg | output | 1 | Result is negative |
| res_int | output | 8 | Integer part magnitude, two BCD digits |
| res_frac | output | 4*FRAC_MAX | Fraction digits, first digit in the top nibble |
| res_len | output | CW | Number of valid fraction digits |

## Verification
A wrong point position or leading-zero count inside the scanner shows up at once on `pw_operand`, in the `pw_req` cycle right after the start is taken. The same fault distorts the characteristic returned with `done`. A wrong iteration count shows either as an extra request after the expected last reply or as a `done` that never arrives. A fault in the ten's complement or carry logic is visible only in the negative results, in the single cycle where `done` rises. For that reason, both a nonzero and an all-zero fraction are driven through the negative path.

// File: rtl/dlog_pkg.sv
package dlog_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_FIN   = 2'd3
   } dlog_state_e;

   // nibble value that marks the decimal point inside a digit vector
   localparam logic [3:0] POINT_CODE = 4'hA;

endpackage

// File: rtl/dlog_scan.sv
// Integer-digit counter and normaliser: strips the point marker, counts the
// integer digits from the first nonzero one and left-aligns the digits.
module dlog_scan
   import dlog_pkg::*;
#(
   parameter  int NDIG = 16,
   localparam int LW   = $clog2(NDIG + 1)
)(
   input  logic [4*NDIG-1:0]  raw,
   output logic [4*NDIG-1:0]  mant,
   output logic               all_zero,
   output logic signed [LW:0] char_s
);

   logic [NDIG-1:0]   is_mark;
   logic [NDIG-1:0]   is_nz;
   logic [4*NDIG-1:0] clean_v;
   logic [LW-1:0]     mark_pos;
   logic [LW-1:0]     int_len;
   logic [LW-1:0]     top_nz;
   logic [LW-1:0]     lead_z;
   logic              mark_seen;

   for (genvar g = 0; g < NDIG; g++) begin : g_mark
      assign is_mark[g] = (raw[4*g +: 4] == POINT_CODE);
   end

   // highest marker wins
   always_comb begin
      mark_seen = 1'b0;
      mark_pos  = '0;
      for (int i = 0; i < NDIG; i++) begin
         if (is_mark[i]) begin
            mark_seen = 1'b1;
            mark_pos  = LW'(i);
         end
      end
   end

   assign int_len = mark_seen ? (LW'(NDIG - 1) - mark_pos) : LW'(NDIG);

   // digits below the marker move up one position, zero fills the bottom
   for (genvar g = 0; g < NDIG; g++) begin : g_clean
      if (g == 0) begin : g_low
         assign clean_v[3:0] = mark_seen ? 4'd0 : raw[3:0];
      end else begin : g_up
         assign clean_v[4*g +: 4] = (mark_seen && (LW'(g) <= mark_pos)) ?
                                    raw[4*g-4 +: 4] : raw[4*g +: 4];
      end
      assign is_nz[g] = (clean_v[4*g +: 4] != 4'd0);
   end

   always_comb begin
      top_nz   = '0;
      all_zero = 1'b1;
      for (int i = 0; i < NDIG; i++) begin
         if (is_nz[i]) begin
            top_nz   = LW'(i);
            all_zero = 1'b0;
         end
      end
   end

   assign lead_z = all_zero ? '0 : (LW'(NDIG - 1) - top_nz);
   assign mant   = clean_v << (4 * lead_z);
   assign char_s = $signed({1'b0, int_len}) - $signed({1'b0, lead_z})
                   - $signed((LW + 1)'(1));

endmodule

// File: rtl/dlog_fmt.sv
// Result formatter: signed BCD integer part and, for negative results,
// the ten's complement of the fraction digits.
module dlog_fmt #(
   parameter int FRAC_MAX = 8,
   parameter int LW       = 5
)(
   input  logic signed [LW:0]       char_s,
   input  logic [4*FRAC_MAX-1:0]    frac_in,
   output logic                     neg,
   output logic [7:0]               int_bcd,
   output logic [4*FRAC_MAX-1:0]    frac_out
);

   logic [FRAC_MAX:0]       carry;
   logic [4*FRAC_MAX-1:0]   comp;
   logic [LW:0]             mag;
   logic [LW:0]             tens;
   logic [LW:0]             ones;

   assign carry[0] = 1'b1;

   // nine's complement plus one, rippled from the least significant digit
   for (genvar g = 0; g < FRAC_MAX; g++) begin : g_tc
      logic [4:0] sum;
      assign sum            = 5'd9 - {1'b0, frac_in[4*g +: 4]} + {4'd0, carry[g]};
      assign carry[g+1]     = (sum > 5'd9);
      assign comp[4*g +: 4] = carry[g+1] ? 4'(sum - 5'd10) : sum[3:0];
   end

   assign neg = char_s[LW];

   // a carry out of the top digit means the fraction was all zero
   always_comb begin
      if (!neg)
         mag = $unsigned(char_s);
      else if (carry[FRAC_MAX])
         mag = $unsigned(-char_s);
      else
         mag = $unsigned(-char_s) - (LW + 1)'(1);
   end

   assign tens     = mag / (LW + 1)'(10);
   assign ones     = mag % (LW + 1)'(10);
   assign int_bcd  = {tens[3:0], ones[3:0]};
   assign frac_out = neg ? comp : frac_in;

endmodule

// File: rtl/dlog_ctrl.sv
// Sequencer and iteration down counter.
module dlog_ctrl
   import dlog_pkg::*;
#(
   parameter int CW = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          pw_ack,
   input  logic          zero_in,
   input  logic [CW-1:0] cnt_load,
   output logic          accept,
   output logic          take,
   output logic          fin,
   output logic          pw_req,
   output logic          busy
);

   dlog_state_e   st_q, st_d;
   logic [CW-1:0] cnt_q;

   assign busy   = (st_q != ST_IDLE);
   assign accept = (st_q == ST_IDLE) && start;
   assign take   = (st_q == ST_WAIT) && pw_ack;
   assign fin    = (st_q == ST_FIN);
   assign pw_req = (st_q == ST_ISSUE);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (start)
                      st_d = (zero_in || (cnt_load == '0)) ? ST_FIN : ST_ISSUE;
         ST_ISSUE: st_d = ST_WAIT;
         ST_WAIT:  if (pw_ack)
                      st_d = (cnt_q == CW'(1)) ? ST_FIN : ST_ISSUE;
         ST_FIN:   st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept)
            cnt_q <= cnt_load;
         else if (take)
            cnt_q <= cnt_q - CW'(1);
      end
   end

endmodule

// File: rtl/declog_engine.sv
module declog_engine
   import dlog_pkg::*;
#(
   parameter  int NDIG     = 16,
   parameter  int FRAC_MAX = 8,
   localparam int LW       = $clog2(NDIG + 1),
   localparam int CW       = $clog2(FRAC_MAX + 1)
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [4*NDIG-1:0]     in_digits,
   input  logic [CW-1:0]         frac_cnt,
   input  logic                  pw_ack,
   input  logic [4*NDIG-1:0]     pw_result,
   output logic                  pw_req,
   output logic [4*NDIG-1:0]     pw_operand,
   output logic                  busy,
   output logic                  done,
   output logic                  res_err,
   output logic                  res_neg,
   output logic [7:0]            res_int,
   output logic [4*FRAC_MAX-1:0] res_frac,
   output logic [CW-1:0]         res_len
);

   if (NDIG < 8 || NDIG > 64) begin : g_bad_ndig
      $error("declog_engine: NDIG must lie in 8..64");
   end
   if (FRAC_MAX < 1 || FRAC_MAX > 15) begin : g_bad_frac
      $error("declog_engine: FRAC_MAX must lie in 1..15");
   end

   logic                    accept, take, fin;
   logic [4*NDIG-1:0]       scan_src, scan_mant;
   logic                    scan_zero;
   logic signed [LW:0]      scan_char;
   logic [CW-1:0]           cnt_clamp;
   logic signed [LW:0]      char_q;
   logic [4*NDIG-1:0]       op_q;
   logic                    err_q;
   logic [CW-1:0]           len_q, wptr_q;
   logic [4*FRAC_MAX-1:0]   frac_q, fmt_frac;
   logic                    fmt_neg;
   logic [7:0]              fmt_int;

   // 2:1 selector: start operand while idle, power-unit reply otherwise
   assign scan_src   = busy ? pw_result : in_digits;
   assign cnt_clamp  = (frac_cnt > CW'(FRAC_MAX)) ? CW'(FRAC_MAX) : frac_cnt;
   assign pw_operand = op_q;

   dlog_scan #(.NDIG(NDIG)) scan_i (
      .raw      (scan_src),
      .mant     (scan_mant),
      .all_zero (scan_zero),
      .char_s   (scan_char)
   );

   dlog_ctrl #(.CW(CW)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .pw_ack   (pw_ack),
      .zero_in  (scan_zero),
      .cnt_load (cnt_clamp),
      .accept   (accept),
      .take     (take),
      .fin      (fin),
      .pw_req   (pw_req),
      .busy     (busy)
   );

   dlog_fmt #(.FRAC_MAX(FRAC_MAX), .LW(LW)) fmt_i (
      .char_s   (char_q),
      .frac_in  (frac_q),
      .neg      (fmt_neg),
      .int_bcd  (fmt_int),
      .frac_out (fmt_frac)
   );

   // working value, characteristic and fraction digit store
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         char_q <= '0;
         op_q   <= '0;
         err_q  <= 1'b0;
         len_q  <= '0;
         wptr_q <= '0;
         frac_q <= '0;
      end else if (accept) begin
         char_q <= scan_char;
         op_q   <= scan_mant;
         err_q  <= scan_zero;
         len_q  <= cnt_clamp;
         wptr_q <= CW'(FRAC_MAX - 1);
         frac_q <= '0;
      end else if (take) begin
         op_q   <= scan_mant;
         wptr_q <= wptr_q - CW'(1);
         for (int i = 0; i < FRAC_MAX; i++) begin
            if (wptr_q == CW'(i))
               frac_q[4*i +: 4] <= scan_char[3:0];
         end
      end
   end

   // result registers, loaded only on completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         res_err  <= 1'b0;
         res_neg  <= 1'b0;
         res_int  <= '0;
         res_frac <= '0;
         res_len  <= '0;
      end else begin
         done <= fin;
         if (fin) begin
            res_err  <= err_q;
            res_neg  <= err_q ? 1'b0 : fmt_neg;
            res_int  <= err_q ? '0 : fmt_int;
            res_frac <= err_q ? '0 : fmt_frac;
            res_len  <= err_q ? '0 : len_q;
         end
      end
   end

endmodule

// File: rtl/declog_engine_chk.sv
module declog_engine_chk #(
   parameter int FRAC_MAX = 8,
   parameter int CW       = 4
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  done,
   input logic                  busy,
   input logic                  pw_req,
   input logic                  res_err,
   input logic                  res_neg,
   input logic [7:0]            res_int,
   input logic [4*FRAC_MAX-1:0] res_frac,
   input logic [CW-1:0]         res_len
);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   frac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(res_frac) |-> done);

   // R10
   int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(res_int) |-> done);

   // R3
   req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pw_req |-> busy);

   // R3
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pw_req |=> !pw_req);

   // R11
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (res_len <= CW'(FRAC_MAX)));

   // R8
   err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_err) |-> (!res_neg && res_len == '0 && res_int == '0));

endmodule

bind declog_engine declog_engine_chk #(.FRAC_MAX(FRAC_MAX), .CW(CW)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .done     (done),
   .busy     (busy),
   .pw_req   (pw_req),
   .res_err  (res_err),
   .res_neg  (res_neg),
   .res_int  (res_int),
   .res_frac (res_frac),
   .res_len  (res_len)
);

// File: tb/declog_engine_tb_top.sv
`timescale 1ns/1ps
module declog_engine_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] in_digits = '0;
   logic [3:0]  frac_cnt = '0;
   logic        pw_ack = 1'b0;
   logic [63:0] pw_result = '0;
   logic        pw_req;
   logic [63:0] pw_operand;
   logic        busy, done, res_err, res_neg;
   logic [7:0]  res_int;
   logic [31:0] res_frac;
   logic [3:0]  res_len;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   declog_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .in_digits(in_digits),
      .frac_cnt(frac_cnt), .pw_ack(pw_ack), .pw_result(pw_result),
      .pw_req(pw_req), .pw_operand(pw_operand), .busy(busy), .done(done),
      .res_err(res_err), .res_neg(res_neg), .res_int(res_int),
      .res_frac(res_frac), .res_len(res_len)
   );

   task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic kick(logic [63:0] val, logic [3:0] cnt);
      @(negedge clk);
      in_digits = val;
      frac_cnt  = cnt;
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
   endtask

   // power unit model: waits for a request, checks the operand, replies
   task automatic serve(string tag, logic [63:0] exp_op, logic [63:0] reply);
      while (!pw_req) @(negedge clk);
      cmp({tag, " R3 operand"}, pw_operand, exp_op);
      @(negedge clk);
      @(negedge clk);
      pw_ack    = 1'b1;
      pw_result = reply;
      @(negedge clk);
      pw_ack    = 1'b0;
   endtask

   task automatic finish_chk(string tag, logic neg, logic [7:0] ip,
                             logic [31:0] fr, logic [3:0] len, logic err);
      int reqs = 0;
      while (!done) begin
         if (pw_req) reqs++;
         @(negedge clk);
      end
      cmp({tag, " R5 no extra request"}, 64'(reqs), 64'd0);
      cmp({tag, " R7 sign"},  64'(res_neg), 64'(neg));
      cmp({tag, " R2 int"},   64'(res_int), 64'(ip));
      cmp({tag, " R4 frac"},  64'(res_frac), 64'(fr));
      cmp({tag, " R12 len"},  64'(res_len), 64'(len));
      cmp({tag, " R8 err"},   64'(res_err), 64'(err));
      @(negedge clk);
      cmp({tag, " R10 done pulse"}, 64'(done), 64'd0);
   endtask

   task automatic t_reset();
      cmp("R1 done",  64'(done), 64'd0);
      cmp("R1 busy",  64'(busy), 64'd0);
      cmp("R1 req",   64'(pw_req), 64'd0);
      cmp("R1 err",   64'(res_err), 64'd0);
      cmp("R1 frac",  64'(res_frac), 64'd0);
      cmp("R1 int",   64'({res_neg, res_int, res_len}), 64'd0);
   endtask

   task automatic t_positive();
      kick(64'h123456789A123456, 4'd3);
      serve("pos1", 64'h1234567891234560, 64'h8A22526267372312);
      serve("pos2", 64'h8225262673723120, 64'h1417417401A84438);
      serve("pos3", 64'h1417417401844380, 64'h32A7323814451385);
      finish_chk("pos R2 R4", 1'b0, 8'h08, 32'h0910_0000, 4'd3, 1'b0);
      repeat (6) @(negedge clk);
      cmp("R10 hold frac", 64'(res_frac), 64'h0910_0000);
      cmp("R10 hold int",  64'(res_int), 64'h08);
   endtask

   task automatic t_negative();
      kick(64'h0A00000123456789, 4'd3);
      serve("neg1 R6", 64'h1234567890000000, 64'h8A22526259147102);
      serve("neg2", 64'h8225262591471020, 64'h1417417260A10355);
      serve("neg3", 64'h1417417260103550, 64'h32A7323487129826);
      finish_chk("neg R6 R7", 1'b1, 8'h05, 32'h9090_0000, 4'd3, 1'b0);
   endtask

   task automatic t_neg_zero_frac();
      kick(64'h0A01000000000000, 4'd1);
      serve("negz R6", 64'h1000000000000000, 64'h1A00000000000000);
      finish_chk("negz R7", 1'b1, 8'h02, 32'h0, 4'd1, 1'b0);
   endtask

   task automatic t_zero_err();
      kick(64'h000A000000000000, 4'd3);
      finish_chk("zero R8", 1'b0, 8'h00, 32'h0, 4'd0, 1'b1);
   endtask

   task automatic t_no_frac();
      kick(64'h0000000000000500, 4'd0);
      finish_chk("nofrac R5 R2", 1'b0, 8'h02, 32'h0, 4'd0, 1'b0);
   endtask

   task automatic t_clamp();
      kick(64'h1000000000000000, 4'd15);
      for (int k = 0; k < 8; k++)
         serve("clamp R11", 64'h1000000000000000, 64'h1A00000000000000);
      finish_chk("clamp R11", 1'b0, 8'h15, 32'h0, 4'd8, 1'b0);
   endtask

   task automatic t_busy_start();
      kick(64'h2A00000000000000, 4'd1);
      while (!pw_req) @(negedge clk);
      cmp("busy R3 operand", pw_operand, 64'h2000000000000000);
      @(negedge clk);
      in_digits = 64'h0A00000000000001;
      frac_cnt  = 4'd0;
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
      cmp("R9 still busy", 64'(busy), 64'd1);
      cmp("R9 no done", 64'(done), 64'd0);
      pw_ack    = 1'b1;
      pw_result = 64'h1024A00000000000;
      @(negedge clk);
      pw_ack    = 1'b0;
      finish_chk("busy R9", 1'b0, 8'h00, 32'h3000_0000, 4'd1, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_positive();
      t_negative();
      t_neg_zero_frac();
      t_zero_err();
      t_no_frac();
      t_clamp();
      t_busy_start();
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete (R5)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule